// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks the instructions in flight through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes every exception precise. Each in-flight slot carries a fault flag and a cause code. The decode stage can raise an undefined-opcode fault. The execute stage can raise an undefined-opcode or divide-by-zero fault. Nothing is acted on where it is detected: the fault rides along with its instruction until that instruction reaches the memory stage, which is the single commit point.

At the commit point the controller either lets the instruction's architectural effects happen or takes a trap. Those effects are the store enable in the memory stage and the register write in writeback. A trap is taken when the committing instruction carries a fault or when the external interrupt line is high. Taking a trap suppresses the committing instruction's store and its writeback. It also empties every younger slot, latches the PC and cause of the trapped instruction, and redirects fetch to a fixed handler address. Every older instruction has already passed the commit point and finishes normally, so the architectural state looks as if execution stopped between two instructions. After the handler runs, software either abandons the program or resumes at the latched PC.

Top module: `pcx_commit_ctl`

## Requirements
- R1: While reset is held and in the cycle after it is released, mem_we, wb_we and take_exc are 0, and epc, ecause and redirect_pc are 0.
- R2: An instruction presented on the fetch inputs before clock edge k with no fault has mem_pc equal to its PC in the cycle after edge k+2. In that cycle mem_we follows its store flag. In the next cycle wb_we follows its register-write flag and wb_pc shows its PC.
- R3: An instruction flagged by id_undef while it sits in decode traps with cause 1 when it reaches the memory stage. Its store and register write never happen.
- R4: An instruction flagged in execute traps with cause 1 for ex_undef and cause 2 for ex_div0. When both are high in the same cycle, cause 1 wins.
- R5: All instructions older than a trapped one complete, with their store and register write.
- R6: When a trap is taken, the instructions in decode, execute and fetch in that cycle are discarded. None of them ever asserts mem_we or wb_we.
- R7: If an older instruction in execute and a younger one in decode are flagged in the same cycle, the older one's cause is taken. An instruction flagged in decode keeps cause 1 even if execute also flags it.
- R8: irq high while a valid, fault-free instruction is in the memory stage takes a trap with cause 3. Its PC becomes epc and its store and register write are suppressed. irq high with an empty memory stage has no effect.
- R9: epc and ecause load the trapped PC and cause at the clock edge that ends the trap cycle. They hold their value until the next trap.
- R10: take_exc is high for exactly the trap cycle, and redirect_pc equals the handler address in that cycle and 0 otherwise. take_exc is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | A fetched instruction is presented this cycle |
| if_pc | input | 32 | PC of the fetched instruction |
| if_store | input | 1 | Fetched instruction writes data memory |
| if_regwr | input | 1 | Fetched instruction writes the register file |
| id_undef | input | 1 | Decode finds the instruction in decode undefined |
| ex_undef | input | 1 | Execute finds the instruction in execute undefined |
| ex_div0 | input | 1 | Execute finds a zero divisor |
| irq | input | 1 | External interrupt request |
| mem_we | output | 1 | Data memory write enable of the committing instruction |
| mem_pc | output | 32 | PC of the instruction in the memory stage |
| wb_we | output | 1 | Register file write enable in writeback |
| wb_pc | output | 32 | PC of the instruction in writeback |
| take_exc | output | 1 | Trap taken this cycle; flushes and redirects fetch |
| redirect_pc | output | 32 | Handler address while take_exc is high, else 0 |
| epc | output | 32 | Latched PC of the last trapped instruction |
| ecause | output | 4 | Latched cause of the last trap |

## Verification
The instruction stream is driven in several patterns. A fault-free stream shows the normal stage timing of the store and writeback enables. A single decode fault and a single execute fault in mid-stream separate the completion of older instructions from the discarding of younger ones. Two faults raised in the same cycle on neighbouring instructions, and two faults raised on the same instruction, show that the oldest and earliest-detected fault is the one taken. An interrupt raised mid-stream is distinguished from one raised with the pipeline empty, which must leave the latched PC and cause untouched.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  parameter int PC_W     = 32;
  parameter int CAUSE_W  = 4;
  parameter int N_STAGES = 4;

  localparam int ID_IX  = 1;
  localparam int EX_IX  = 2;
  localparam int MEM_IX = N_STAGES - 1;
  localparam int WB_IX  = N_STAGES;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] CAUSE_DIV0  = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = CAUSE_W'(3);

  typedef struct packed {
    logic              vld;
    logic [PC_W-1:0]   pc;
    logic              st;
    logic              rw;
    logic              exc;
    logic [CAUSE_W-1:0] cause;
  } slot_t;

  // A fault is recorded only on a live slot that has no earlier fault.
  function automatic slot_t attach_fault(slot_t s, logic hit, logic [CAUSE_W-1:0] c);
    slot_t r;
    r = s;
    if (s.vld && !s.exc && hit) begin
      r.exc   = 1'b1;
      r.cause = c;
    end
    return r;
  endfunction

  // Undefined opcode outranks divide-by-zero inside the execute stage.
  function automatic logic [CAUSE_W-1:0] ex_cause_pick(logic und, logic dz);
    if (und)     return CAUSE_UNDEF;
    else if (dz) return CAUSE_DIV0;
    else         return CAUSE_NONE;
  endfunction

  function automatic logic trap_due(slot_t m, logic irq);
    return m.vld && (m.exc || irq);
  endfunction

  function automatic logic [CAUSE_W-1:0] trap_cause(slot_t m);
    return m.exc ? m.cause : CAUSE_IRQ;
  endfunction
endpackage

// File: rtl/pcx_stage_reg.sv
module pcx_stage_reg
  import pcx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  slot_t              d,
  input  logic               hit,
  input  logic [CAUSE_W-1:0] hit_cause,
  output slot_t              q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (kill)  q <= '0;
    else            q <= attach_fault(d, hit, hit_cause);
  end
endmodule

// File: rtl/pcx_commit.sv
module pcx_commit
  import pcx_pkg::*;
(
  input  slot_t              mem,
  input  logic               irq,
  output logic               take,
  output logic [CAUSE_W-1:0] cause,
  output logic               st_en
);
  always_comb begin
    take  = trap_due(mem, irq);
    cause = take ? trap_cause(mem) : CAUSE_NONE;
    st_en = mem.vld && mem.st && !take;
  end
endmodule

// File: rtl/pcx_trap_regs.sv
module pcx_trap_regs
  import pcx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [PC_W-1:0]    pc,
  input  logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] ecause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc    <= '0;
      ecause <= CAUSE_NONE;
    end else if (take) begin
      epc    <= pc;
      ecause <= cause;
    end
  end
endmodule

// File: rtl/pcx_commit_ctl.sv
module pcx_commit_ctl
  import pcx_pkg::*;
#(
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               if_valid,
  input  logic [PC_W-1:0]    if_pc,
  input  logic               if_store,
  input  logic               if_regwr,
  input  logic               id_undef,
  input  logic               ex_undef,
  input  logic               ex_div0,
  input  logic               irq,
  output logic               mem_we,
  output logic [PC_W-1:0]    mem_pc,
  output logic               wb_we,
  output logic [PC_W-1:0]    wb_pc,
  output logic               take_exc,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] ecause
);
  slot_t              chain [N_STAGES+1];
  logic               hit_v [N_STAGES];
  logic [CAUSE_W-1:0] hit_c [N_STAGES];

  // Named internal events for the checker.
  logic               take_w;
  logic [CAUSE_W-1:0] cause_w;
  logic               mem_vld_w;
  slot_t              wb_slot_w;

  assign chain[0] = '{vld: if_valid, pc: if_pc, st: if_store, rw: if_regwr,
                      exc: 1'b0, cause: CAUSE_NONE};

  always_comb begin
    for (int i = 0; i < N_STAGES; i++) begin
      hit_v[i] = 1'b0;
      hit_c[i] = CAUSE_NONE;
    end
    hit_v[ID_IX] = id_undef;
    hit_c[ID_IX] = CAUSE_UNDEF;
    hit_v[EX_IX] = ex_undef | ex_div0;
    hit_c[EX_IX] = ex_cause_pick(ex_undef, ex_div0);
  end

  // One register per stage boundary; every one is cleared by a trap.
  generate
    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
      pcx_stage_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (take_w),
        .d         (chain[g]),
        .hit       (hit_v[g]),
        .hit_cause (hit_c[g]),
        .q         (chain[g+1])
      );
    end
  endgenerate

  pcx_commit u_commit (
    .mem   (chain[MEM_IX]),
    .irq   (irq),
    .take  (take_w),
    .cause (cause_w),
    .st_en (mem_we)
  );

  pcx_trap_regs u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take_w),
    .pc     (chain[MEM_IX].pc),
    .cause  (cause_w),
    .epc    (epc),
    .ecause (ecause)
  );

  assign mem_vld_w   = chain[MEM_IX].vld;
  assign wb_slot_w   = chain[WB_IX];
  assign mem_pc      = chain[MEM_IX].pc;
  assign wb_we       = wb_slot_w.vld && wb_slot_w.rw;
  assign wb_pc       = wb_slot_w.pc;
  assign take_exc    = take_w;
  assign redirect_pc = take_w ? HANDLER_PC : '0;
endmodule

// File: rtl/pcx_chk.sv
module pcx_chk
  import pcx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               take,
  input logic               mem_vld,
  input logic [PC_W-1:0]    mem_pc,
  input logic [CAUSE_W-1:0] cause_w,
  input logic               mem_we,
  input logic [PC_W-1:0]    epc,
  input logic [CAUSE_W-1:0] ecause,
  input slot_t              wb_slot
);
  // R9
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc == $past(mem_pc)) && (ecause == $past(cause_w)));

  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(epc) && $stable(ecause));

  // R6
  mem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !mem_vld);

  // R6
  wb_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !wb_slot.vld);

  // R10
  no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R2
  mem_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> wb_slot.vld && wb_slot.st && (wb_slot.pc == $past(mem_pc)));

  // R3
  no_fault_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_slot.vld |-> !wb_slot.exc && (wb_slot.cause == CAUSE_NONE));
endmodule

bind pcx_commit_ctl pcx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .take    (take_w),
  .mem_vld (mem_vld_w),
  .mem_pc  (mem_pc),
  .cause_w (cause_w),
  .mem_we  (mem_we),
  .epc     (epc),
  .ecause  (ecause),
  .wb_slot (wb_slot_w)
);

// File: tb/pcx_commit_ctl_test.sv
module pcx_commit_ctl_test;
  localparam int unsigned HANDLER = 32'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_valid = 1'b0, if_store = 1'b0, if_regwr = 1'b0;
  logic [31:0] if_pc = '0;
  logic        id_undef = 1'b0, ex_undef = 1'b0, ex_div0 = 1'b0, irq = 1'b0;
  logic        mem_we, wb_we, take_exc;
  logic [31:0] mem_pc, wb_pc, redirect_pc, epc;
  logic [3:0]  ecause;

  pcx_commit_ctl uut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_store(if_store), .if_regwr(if_regwr), .id_undef(id_undef),
    .ex_undef(ex_undef), .ex_div0(ex_div0), .irq(irq), .mem_we(mem_we),
    .mem_pc(mem_pc), .wb_we(wb_we), .wb_pc(wb_pc), .take_exc(take_exc),
    .redirect_pc(redirect_pc), .epc(epc), .ecause(ecause)
  );

  always #2 clk = ~clk;

  typedef struct {
    int unsigned pc;
    bit          st;
    bit          rw;
    bit          exc;
    int unsigned cause;
    int          age;
  } rec_t;

  rec_t        q[$];
  bit          id_bad[int unsigned];
  bit          ex_und[int unsigned];
  bit          ex_dz[int unsigned];
  int unsigned m_epc = 0, m_cause = 0;
  int unsigned nxt_pc = 32'h1000;
  int unsigned f_pc = 32'h2000;
  int          n_old = 0, n_young = 0, n_take = 0;
  int          checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus, reference model compare and model advance.
  task automatic step(input bit v, input bit irq_v);
    int mi, wi;
    bit t_take, e_mem_we, e_wb_we;
    int unsigned e_cause;
    rec_t nq[$];
    @(negedge clk);
    if_valid = v; if_pc = nxt_pc; if_store = 1'b1; if_regwr = 1'b1; irq = irq_v;
    id_undef = 1'b0; ex_undef = 1'b0; ex_div0 = 1'b0;
    foreach (q[i]) begin
      if (q[i].age == 1 && id_bad.exists(q[i].pc)) id_undef = 1'b1;
      if (q[i].age == 2 && ex_und.exists(q[i].pc)) ex_undef = 1'b1;
      if (q[i].age == 2 && ex_dz.exists(q[i].pc))  ex_div0  = 1'b1;
    end
    #1;
    mi = -1; wi = -1;
    foreach (q[i]) begin
      if (q[i].age == 3) mi = i;
      if (q[i].age == 4) wi = i;
    end
    t_take   = (mi >= 0) && (q[mi].exc || irq_v);
    e_cause  = t_take ? (q[mi].exc ? q[mi].cause : 3) : 0;
    e_mem_we = (mi >= 0) && q[mi].st && !t_take;
    e_wb_we  = (wi >= 0) && q[wi].rw;
    chk(take_exc == t_take, "R10", "take_exc", take_exc, t_take);
    chk(redirect_pc == (t_take ? HANDLER : 0), "R10", "redirect_pc", redirect_pc, t_take ? HANDLER : 0);
    chk(mem_we == e_mem_we, "R2", "mem_we", mem_we, e_mem_we);
    chk(wb_we == e_wb_we, "R2", "wb_we", wb_we, e_wb_we);
    if (mi >= 0) chk(mem_pc == q[mi].pc, "R2", "mem_pc", mem_pc, q[mi].pc);
    if (wi >= 0) chk(wb_pc == q[wi].pc, "R2", "wb_pc", wb_pc, q[wi].pc);
    chk(epc == m_epc, "R9", "epc", epc, m_epc);
    chk(ecause == m_cause, "R9", "ecause", ecause, m_cause);
    if (wb_we && wb_pc >= 32'h1000 && wb_pc < f_pc) n_old++;
    if ((wb_we && wb_pc >= f_pc && wb_pc < 32'h2000) ||
        (mem_we && mem_pc >= f_pc && mem_pc < 32'h2000)) n_young++;
    if (take_exc) n_take++;
    if (t_take) begin
      m_epc   = q[mi].pc;
      m_cause = e_cause;
    end else begin
      foreach (q[i]) begin
        rec_t r;
        r = q[i];
        if (r.age == 4) continue;
        if (r.age == 1 && id_undef && !r.exc) begin
          r.exc = 1'b1; r.cause = 1;
        end else if (r.age == 2 && (ex_undef || ex_div0) && !r.exc) begin
          r.exc = 1'b1; r.cause = ex_undef ? 1 : 2;
        end
        r.age++;
        nq.push_back(r);
      end
      if (v) nq.push_back('{pc: nxt_pc, st: 1'b1, rw: 1'b1, exc: 1'b0, cause: 0, age: 1});
    end
    q = nq;
    if (t_take) nxt_pc = HANDLER;
    else if (v) nxt_pc += 4;
  endtask

  // Ten fetch cycles from 0x1000 (handler code after a trap), then drain.
  task automatic run(input int unsigned fault_pc, input int irq_cycle);
    f_pc = fault_pc; nxt_pc = 32'h1000;
    n_old = 0; n_young = 0; n_take = 0;
    for (int c = 0; c < 10; c++) step(1'b1, c == irq_cycle);
    for (int c = 0; c < 8; c++) step(1'b0, 1'b0);
  endtask

  task automatic clear_maps();
    id_bad.delete(); ex_und.delete(); ex_dz.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs during reset
    chk(!mem_we && !wb_we && !take_exc, "R1", "enables in reset", {mem_we, wb_we, take_exc}, 0);
    chk(epc == 0 && ecause == 0 && redirect_pc == 0, "R1", "trap regs in reset", epc, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!mem_we && !wb_we && !take_exc, "R1", "enables after release", {mem_we, wb_we, take_exc}, 0);

    // R2: fault-free stream, all ten commit
    clear_maps(); run(32'h2000, -1);
    chk(n_old == 10, "R2", "clean commits", n_old, 10);
    chk(n_take == 0, "R2", "clean traps", n_take, 0);

    // R3 R5 R6: decode fault on the third instruction
    clear_maps(); id_bad[32'h1008] = 1'b1; run(32'h1008, -1);
    chk(epc == 32'h1008, "R3", "epc", epc, 32'h1008);
    chk(ecause == 1, "R3", "ecause", ecause, 1);
    chk(n_old == 2, "R5", "older commits", n_old, 2);
    chk(n_young == 0, "R6", "younger effects", n_young, 0);
    chk(n_take == 1, "R10", "trap count", n_take, 1);

    // R4: divide by zero in execute
    clear_maps(); ex_dz[32'h100C] = 1'b1; run(32'h100C, -1);
    chk(epc == 32'h100C && ecause == 2, "R4", "div0 cause", ecause, 2);
    chk(n_old == 3 && n_young == 0, "R5", "div0 commits", n_old, 3);

    // R4: execute undefined beats div0 on the same instruction
    clear_maps(); ex_und[32'h1004] = 1'b1; ex_dz[32'h1004] = 1'b1; run(32'h1004, -1);
    chk(epc == 32'h1004 && ecause == 1, "R4", "ex undef priority", ecause, 1);
    chk(n_old == 1 && n_young == 0, "R6", "ex undef effects", n_young, 0);

    // R7: older execute fault and younger decode fault in one cycle
    clear_maps(); ex_dz[32'h100C] = 1'b1; id_bad[32'h1010] = 1'b1; run(32'h100C, -1);
    chk(epc == 32'h100C && ecause == 2, "R7", "oldest taken", epc, 32'h100C);
    chk(n_take == 1, "R7", "single trap", n_take, 1);

    // R7: decode fault kept over a later execute fault
    clear_maps(); id_bad[32'h1008] = 1'b1; ex_dz[32'h1008] = 1'b1; run(32'h1008, -1);
    chk(ecause == 1, "R7", "earliest cause kept", ecause, 1);

    // R8: interrupt in cycle 5 lands on the instruction fetched in cycle 2
    clear_maps(); run(32'h1008, 5);
    chk(epc == 32'h1008 && ecause == 3, "R8", "irq epc", epc, 32'h1008);
    chk(n_old == 2 && n_young == 0, "R8", "irq effects", n_young, 0);

    // R8 R9: interrupt with an empty pipeline changes nothing
    n_take = 0;
    for (int c = 0; c < 4; c++) step(1'b0, 1'b1);
    chk(n_take == 0, "R8", "irq on empty pipe", n_take, 0);
    chk(epc == 32'h1008 && ecause == 3, "R9", "trap regs held", epc, 32'h1008);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule